// File: doc/BRIEF.md
# Interrupt-Aware Fetch-Execute Sequencer

This block is the control sequencer of a small stored-program processor. It keeps the program counter, the instruction register, a supervisor/user mode bit and an interrupt mask. It walks through fetch and execute phases against a single word-addressed memory port. A read puts the address and a read command on the port for one cycle, and the word is taken one cycle later. The arithmetic datapath is outside the block. It sees one `exec_o` strobe for each instruction and reports completion on `exec_done_i`, after which the program counter advances by one word.

When a fetch completes, the block samples the level-sensitive request `irq_i`. If the request is high and interrupts are not masked, the fetched word is dropped. The address of that word is written to memory word 0, and the handler address is read from memory word 1. The handler's first instruction is then fetched in supervisor mode, and interrupts stay masked until software unmasks them. A halt opcode stops the sequencer until the next reset.

The opcode is the top four bits of the instruction word. Four values are decoded here. Every other value goes to the datapath and has no effect on the sequencer.

Top module: `fetch_seq`

## Requirements
- R1: While `rst_ni` is low, `pc_o` equals RESET_PC (default 2), `sup_mode_o` is 1, `irq_masked_o` is 0, `halt_o` is 0 and `exec_o` is 0. The first read after reset goes to address RESET_PC.
- R2: Each instruction that is not taken over by an interrupt and is not a halt gives exactly one single-cycle `exec_o` pulse, with `ir_o` equal to the fetched word and `pc_o` equal to its address. After `exec_done_i`, the next fetch is from `pc_o + 1` modulo 2^AW.
- R3: A read drives `mem_rd_o` for one cycle with `mem_addr_o`, and the word is taken from `mem_rdata_i` in the following cycle. `mem_rd_o` and `mem_wr_o` are never high together.
- R4: If `irq_i` is high and `irq_masked_o` is low in the cycle a fetched word arrives, that word is discarded: it gives no `exec_o` pulse and is not loaded into `ir_o`.
- R5: On interrupt entry the block writes, in one cycle, the address of the discarded word to memory address 0.
- R6: After that save, the block reads memory address 1. The low AW bits of the word read become the new program counter, and the next fetch is from that address.
- R7: Interrupt entry sets supervisor mode and sets `irq_masked_o`. While it is set, `irq_i` is ignored, until an instruction with opcode 4'hD (bits DW-1:DW-4) executes and clears it.
- R8: Opcode 4'hE (trap) sets `sup_mode_o` to 1 and opcode 4'hC sets it to 0. The change is visible from the cycle after that instruction's `exec_o` pulse.
- R9: A fetched word with opcode 4'hF (halt), when no interrupt is taken, sets `halt_o`. It gives no `exec_o` pulse, and from then until reset there are no memory commands and `pc_o` does not change.
- R10: If a halt word arrives in the same cycle as a pending, unmasked interrupt request, the interrupt is taken and the halt is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 1 | Level-sensitive interrupt request |
| exec_done_i | input | 1 | Datapath has finished the current instruction |
| mem_rdata_i | input | DW | Read data, valid one cycle after a read command |
| mem_addr_o | output | AW | Memory word address |
| mem_rd_o | output | 1 | Read command |
| mem_wr_o | output | 1 | Write command, completes in one cycle |
| mem_wdata_o | output | DW | Write data |
| exec_o | output | 1 | Execute strobe for the current instruction |
| ir_o | output | DW | Instruction register |
| pc_o | output | AW | Program counter |
| halt_o | output | 1 | Halt flag |
| sup_mode_o | output | 1 | 1 = supervisor mode, 0 = user mode |
| irq_masked_o | output | 1 | Interrupts blocked |

## Verification
Two events can land in the same cycle: a halt word arriving from memory, and the test of a pending interrupt that follows every fetch. A directed program places a halt right after an ordinary instruction, and `irq_i` is raised at that instruction's execute strobe. The check is that the next strobe comes from the handler address, word 0 holds the halt word's address, and `halt_o` stays low. Random runs also raise requests near mode and unmask opcodes. A bench reference model predicts each strobe's address, word, mode and mask.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  typedef enum logic [2:0] {
    ST_FREQ, ST_FWAIT, ST_EXEC, ST_EWAIT, ST_SAVE, ST_VREQ, ST_VWAIT, ST_HALT
  } seq_state_e;

  localparam int OPW = 4;
  localparam logic [OPW-1:0] OP_HALT   = 4'hF;
  localparam logic [OPW-1:0] OP_TRAP   = 4'hE;
  localparam logic [OPW-1:0] OP_UNMASK = 4'hD;
  localparam logic [OPW-1:0] OP_USER   = 4'hC;

  localparam int SAVE_ADDR = 0;
  localparam int VEC_ADDR  = 1;
endpackage

// File: rtl/fseq_decode.sv
module fseq_decode
  import fseq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] word_i,
  output logic          is_halt_o,
  output logic          is_trap_o,
  output logic          is_unmask_o,
  output logic          is_user_o
);
  localparam int OP_LSB = DW - OPW;

  logic [OPW-1:0] op;
  assign op = word_i[DW-1:OP_LSB];

  assign is_halt_o   = (op == OP_HALT);
  assign is_trap_o   = (op == OP_TRAP);
  assign is_unmask_o = (op == OP_UNMASK);
  assign is_user_o   = (op == OP_USER);
endmodule

// File: rtl/fseq_pc.sv
module fseq_pc #(
  parameter int AW       = 6,
  parameter int RESET_PC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  output logic [AW-1:0] pc_o
);
  localparam logic [AW-1:0] PC_INIT = AW'(RESET_PC);
  localparam logic [AW-1:0] PC_STEP = AW'(1);

  logic [AW-1:0] pc_q;

  // wraps modulo 2**AW by width
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pc_q <= PC_INIT;
    else if (load_i) pc_q <= load_val_i;
    else if (inc_i)  pc_q <= pc_q + PC_STEP;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
  import fseq_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          irq_i,
  input  logic          exec_done_i,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic [AW-1:0] pc_i,
  output logic          pc_inc_o,
  output logic          pc_load_o,
  output logic [AW-1:0] pc_load_val_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          exec_o,
  output logic [DW-1:0] ir_o,
  output logic          halt_o,
  output logic          sup_mode_o,
  output logic          irq_masked_o
);
  localparam logic [AW-1:0] A_SAVE = AW'(SAVE_ADDR);
  localparam logic [AW-1:0] A_VEC  = AW'(VEC_ADDR);

  seq_state_e    state_q, state_d;
  logic [DW-1:0] ir_q;
  logic          sup_q, mask_q;
  logic          take_irq;
  logic          rd_halt, rd_trap_unused, rd_unmask_unused, rd_user_unused;
  logic          ir_halt_unused, ir_trap, ir_unmask, ir_user;

  // raw read data: halt is caught before the word reaches IR
  fseq_decode #(.DW(DW)) u_dec_rd (
    .word_i      (mem_rdata_i),
    .is_halt_o   (rd_halt),
    .is_trap_o   (rd_trap_unused),
    .is_unmask_o (rd_unmask_unused),
    .is_user_o   (rd_user_unused)
  );

  fseq_decode #(.DW(DW)) u_dec_ir (
    .word_i      (ir_q),
    .is_halt_o   (ir_halt_unused),
    .is_trap_o   (ir_trap),
    .is_unmask_o (ir_unmask),
    .is_user_o   (ir_user)
  );

  assign take_irq = irq_i && !mask_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FREQ:  state_d = ST_FWAIT;
      ST_FWAIT: begin
        if (take_irq)     state_d = ST_SAVE;
        else if (rd_halt) state_d = ST_HALT;
        else              state_d = ST_EXEC;
      end
      ST_EXEC:  state_d = ST_EWAIT;
      ST_EWAIT: if (exec_done_i) state_d = ST_FREQ;
      ST_SAVE:  state_d = ST_VREQ;
      ST_VREQ:  state_d = ST_VWAIT;
      ST_VWAIT: state_d = ST_FREQ;
      ST_HALT:  state_d = ST_HALT;
      default:  state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FREQ;
      ir_q    <= '0;
      sup_q   <= 1'b1;
      mask_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_FWAIT && !take_irq) ir_q <= mem_rdata_i;
      if (state_q == ST_VWAIT) begin
        sup_q  <= 1'b1;
        mask_q <= 1'b1;
      end else if (state_q == ST_EXEC) begin
        if (ir_trap)        sup_q  <= 1'b1;
        else if (ir_user)   sup_q  <= 1'b0;
        if (ir_unmask)      mask_q <= 1'b0;
      end
    end
  end

  always_comb begin
    mem_addr_o = pc_i;
    if (state_q == ST_SAVE)      mem_addr_o = A_SAVE;
    else if (state_q == ST_VREQ) mem_addr_o = A_VEC;
  end

  assign mem_rd_o      = (state_q == ST_FREQ) || (state_q == ST_VREQ);
  assign mem_wr_o      = (state_q == ST_SAVE);
  assign mem_wdata_o   = DW'(pc_i);
  assign exec_o        = (state_q == ST_EXEC);
  assign pc_inc_o      = (state_q == ST_EWAIT) && exec_done_i;
  assign pc_load_o     = (state_q == ST_VWAIT);
  assign pc_load_val_o = mem_rdata_i[AW-1:0];
  assign ir_o          = ir_q;
  assign halt_o        = (state_q == ST_HALT);
  assign sup_mode_o    = sup_q;
  assign irq_masked_o  = mask_q;
endmodule

// File: rtl/fetch_seq.sv
module fetch_seq #(
  parameter int AW       = 6,
  parameter int DW       = 16,
  parameter int RESET_PC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          irq_i,
  input  logic          exec_done_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          exec_o,
  output logic [DW-1:0] ir_o,
  output logic [AW-1:0] pc_o,
  output logic          halt_o,
  output logic          sup_mode_o,
  output logic          irq_masked_o
);
  logic          pc_inc, pc_load;
  logic [AW-1:0] pc_load_val;

  fseq_pc #(.AW(AW), .RESET_PC(RESET_PC)) u_pc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inc_i      (pc_inc),
    .load_i     (pc_load),
    .load_val_i (pc_load_val),
    .pc_o       (pc_o)
  );

  fseq_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .irq_i         (irq_i),
    .exec_done_i   (exec_done_i),
    .mem_rdata_i   (mem_rdata_i),
    .pc_i          (pc_o),
    .pc_inc_o      (pc_inc),
    .pc_load_o     (pc_load),
    .pc_load_val_o (pc_load_val),
    .mem_addr_o    (mem_addr_o),
    .mem_rd_o      (mem_rd_o),
    .mem_wr_o      (mem_wr_o),
    .mem_wdata_o   (mem_wdata_o),
    .exec_o        (exec_o),
    .ir_o          (ir_o),
    .halt_o        (halt_o),
    .sup_mode_o    (sup_mode_o),
    .irq_masked_o  (irq_masked_o)
  );
endmodule

// File: rtl/fetch_seq_chk.sv
module fetch_seq_chk #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_rd_o,
  input logic          mem_wr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          exec_o,
  input logic [AW-1:0] pc_o,
  input logic          halt_o,
  input logic          sup_mode_o,
  input logic          irq_masked_o
);
  AST_NO_RDWR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o)); // R3
  AST_RD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o); // R3
  AST_EXEC_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o |=> !exec_o); // R2
  AST_SAVE_WORD0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> (mem_addr_o == '0) && (mem_wdata_o == DW'(pc_o))); // R5
  AST_VEC_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |=> mem_rd_o && (mem_addr_o == AW'(1))); // R6
  AST_ENTRY_SUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_masked_o) |-> sup_mode_o); // R7
  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o && !mem_rd_o && !mem_wr_o && !exec_o && $stable(pc_o)); // R9
endmodule

bind fetch_seq fetch_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mem_addr_o   (mem_addr_o),
  .mem_rd_o     (mem_rd_o),
  .mem_wr_o     (mem_wr_o),
  .mem_wdata_o  (mem_wdata_o),
  .exec_o       (exec_o),
  .pc_o         (pc_o),
  .halt_o       (halt_o),
  .sup_mode_o   (sup_mode_o),
  .irq_masked_o (irq_masked_o)
);

// File: tb/tb_fetch_seq.sv
`timescale 1ns/1ps
module tb_fetch_seq;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int RESET_PC = 2;
  localparam int DEPTH = 1 << AW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          irq_i = 1'b0;
  logic          exec_done_i = 1'b0;
  logic [DW-1:0] mem_rdata_i = '0;
  logic [AW-1:0] mem_addr_o;
  logic          mem_rd_o, mem_wr_o, exec_o, halt_o, sup_mode_o, irq_masked_o;
  logic [DW-1:0] mem_wdata_o, ir_o;
  logic [AW-1:0] pc_o;

  fetch_seq #(.AW(AW), .DW(DW), .RESET_PC(RESET_PC)) dut (.*);

  always #10 clk_i = ~clk_i;

  logic [DW-1:0] tbmem  [DEPTH];
  logic [DW-1:0] refmem [DEPTH];

  always @(posedge clk_i) begin
    if (mem_rd_o) mem_rdata_i <= tbmem[mem_addr_o];
    if (mem_wr_o) tbmem[mem_addr_o] <= mem_wdata_o;
  end

  int n_chk = 0, n_fail = 0;
  bit reported = 0;
  logic [AW-1:0] ref_pc, last_pc;
  logic ref_sup, ref_mask, save_pending, saw_halt;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  function automatic logic [DW-1:0] rand_word();
    int v = $urandom % 32;
    logic [3:0] op;
    if (v < 24)      op = 4'(v % 12);
    else if (v < 27) op = 4'hC;
    else if (v < 29) op = 4'hD;
    else if (v < 31) op = 4'hE;
    else             op = 4'hF;
    return {op, 12'($urandom)};
  endfunction

  function automatic logic [DW-1:0] gen_word();
    return {4'($urandom % 12), 12'($urandom)};
  endfunction

  task automatic put(input int a, input logic [DW-1:0] w);
    tbmem[a] = w;
    refmem[a] = w;
  endtask

  task automatic take_irq();
    if (irq_i && !ref_mask) begin
      refmem[0] = DW'(ref_pc);
      ref_pc = refmem[1][AW-1:0];
      ref_sup = 1'b1;
      ref_mask = 1'b1;
      save_pending = 1'b1;
    end
  endtask

  // R1: reset state and first fetch address
  task automatic start_phase(input logic irq0);
    rst_ni = 1'b0;
    exec_done_i = 1'b0;
    irq_i = irq0;
    repeat (3) @(negedge clk_i);
    chk(pc_o == AW'(RESET_PC), "R1 reset pc", pc_o, RESET_PC);
    chk(sup_mode_o && !irq_masked_o && !halt_o && !exec_o && !mem_wr_o,
        "R1 reset flags", {sup_mode_o, irq_masked_o, halt_o, exec_o, mem_wr_o}, 5'b10000);
    chk(mem_rd_o && mem_addr_o == AW'(RESET_PC), "R1 first fetch addr", mem_addr_o, RESET_PC);
    rst_ni = 1'b1;
    ref_pc = AW'(RESET_PC);
    ref_sup = 1'b1;
    ref_mask = 1'b0;
    save_pending = 1'b0;
    saw_halt = 1'b0;
    take_irq();
  endtask

  task automatic run(input int n, input int pol);
    bit stop = 0;
    for (int i = 0; i < n && !stop; i++) begin
      logic [DW-1:0] w = refmem[ref_pc];
      bit exp_halt = (w[DW-1:DW-4] == 4'hF);
      int k = 0;
      do begin
        @(negedge clk_i);
        if (mem_rd_o && mem_wr_o) chk(0, "R3 read and write together", 1, 0);
        k++;
      end while (!exec_o && !halt_o && k < 200);
      if (k >= 200) begin
        chk(0, "R2 no strobe or halt within window", 0, 1);
        stop = 1;
      end else if (halt_o) begin
        logic [AW-1:0] pc_h = pc_o;
        bit ok = 1;
        saw_halt = 1'b1;
        chk(exp_halt, "R9 halt on non-halt word", w, 16'hF000);
        repeat (8) begin
          @(negedge clk_i);
          ok &= halt_o && !exec_o && !mem_rd_o && !mem_wr_o && pc_o == pc_h;
        end
        chk(ok, "R9 halted sequencer idle", ok, 1);
        stop = 1;
      end else begin
        last_pc = pc_o;
        chk(!exp_halt, "R9 strobe on halt word", w, 0);
        chk(pc_o == ref_pc, "R2/R4/R6 strobe pc", pc_o, ref_pc);
        chk(ir_o == w, "R2 instruction register", ir_o, w);
        chk(sup_mode_o == ref_sup, "R8 mode bit", sup_mode_o, ref_sup);
        chk(irq_masked_o == ref_mask, "R7 mask bit", irq_masked_o, ref_mask);
        if (save_pending) chk(tbmem[0] == refmem[0], "R5 saved pc in word 0", tbmem[0], refmem[0]);
        save_pending = 1'b0;
        case (w[DW-1:DW-4])
          4'hE: ref_sup = 1'b1;
          4'hC: ref_sup = 1'b0;
          4'hD: ref_mask = 1'b0;
          default: ;
        endcase
        ref_pc = ref_pc + 1'b1;
        irq_i = (pol == 0) ? 1'b0 : (pol == 1) ? 1'b1 : (($urandom % 4) == 0);
        take_irq();
        @(negedge clk_i);
        repeat ($urandom % 3) @(negedge clk_i);
        exec_done_i = 1'b1;
        @(negedge clk_i);
        exec_done_i = 1'b0;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));

    // R2: straight-line code wrapping past the top of memory
    for (int a = 0; a < DEPTH; a++) put(a, gen_word());
    start_phase(1'b0);
    run(70, 0);
    chk(!saw_halt && last_pc == AW'((RESET_PC + 69) % DEPTH), "R2 wrap", last_pc, (RESET_PC + 69) % DEPTH);

    // R8: user and trap opcodes, then halt
    for (int a = 0; a < DEPTH; a++) put(a, gen_word());
    put(2, 16'hC000); put(4, 16'hE123); put(6, 16'hF000);
    start_phase(1'b0);
    run(10, 0);
    chk(saw_halt && pc_o == AW'(6), "R9 halt address", pc_o, 6);

    // R10 and R7: interrupt against halt word, masking, unmask re-entry
    for (int a = 0; a < DEPTH; a++) put(a, gen_word());
    put(1, 16'd20); put(3, 16'hF000); put(22, 16'hD000); put(24, 16'hF000);
    start_phase(1'b0);
    run(1, 1);
    run(1, 1);
    chk(!saw_halt && last_pc == AW'(20), "R10 interrupt beats halt", last_pc, 20);
    chk(tbmem[0] == 16'd3, "R5 word 0 holds halt address", tbmem[0], 3);
    run(2, 1);
    run(1, 0);
    chk(last_pc == AW'(20) && tbmem[0] == 16'd23, "R7 re-entry after unmask", {tbmem[0][7:0], 2'b0, last_pc}, {8'd23, 8'd20});
    run(20, 0);
    chk(saw_halt, "R9 halt in handler", saw_halt, 1);

    // R4: request already high at the first fetch
    for (int a = 0; a < DEPTH; a++) put(a, gen_word());
    put(1, 16'd40);
    start_phase(1'b1);
    run(1, 1);
    chk(last_pc == AW'(40), "R4 first fetch discarded", last_pc, 40);

    // random programs
    for (int p = 0; p < 8; p++) begin
      for (int a = 0; a < DEPTH; a++) put(a, rand_word());
      put(1, 16'(2 + ($urandom % (DEPTH - 2))));
      start_phase(1'($urandom % 2));
      run(300, 2);
    end

    report();
  end
endmodule